// File: doc/BRIEF.md
# Rotating-Window Integer Register File

This block is the integer register file of a pipelined core whose calling convention rotates a window over a larger physical store. Software always addresses 32 registers through a 5-bit number. Numbers 0 to 7 reach a bank of globals that every window shares. Numbers 8 to 31 reach 24 registers that belong to the current window. A call moves the window pointer to a fresh position and a return moves it back. The caller's private registers therefore survive the call. Neighbouring windows overlap by eight registers, so the caller's argument registers become the callee's incoming registers without any copy.

Two read ports are combinational. The single write port updates storage on the rising clock edge and is forwarded to a same-cycle read of the same number. The trap logic supplies a mask with one bit per window that marks windows that may not be entered. When a call or return would enter a marked window, the pointer stays where it is and a one-cycle overflow or underflow flag is raised so that the trap logic can spill or fill the window. The number of windows is a parameter in the range 3 to 32.

Top module: `winreg_file`

## Requirements
- R1: Register numbers 1 to 7 select one global bank that is shared by all windows. A value written to a global register is read back unchanged from any window.
- R2: Register number 0 always reads as zero on both read ports. A write to number 0 has no effect.
- R3: Numbers 16 to 23 select eight registers that are private to the current window. A value written there is still present after the window has moved away and come back.
- R4: Numbers 24 to 31 select the incoming group of the current window w. Numbers 8 to 15 select the outgoing group of window w, which is the same storage as the incoming group of window (w-1) mod NWIN. Register 8+k of a caller is therefore register 24+k of its callee.
- R5: When `call_req` is high, `cwp` decrements modulo NWIN at the clock edge. When `ret_req` is high and `call_req` is low, `cwp` increments modulo NWIN at the clock edge. Both directions wrap between 0 and NWIN-1.
- R6: When a call targets a window whose bit in `inval_mask` is 1, `cwp` does not change. `ovf` is then 1 for the cycle after that edge, and `ovf` is 0 in every other cycle.
- R7: When a return targets a window whose bit in `inval_mask` is 1, `cwp` does not change. `unf` is then 1 for the cycle after that edge, and `unf` is 0 in every other cycle.
- R8: When `call_req` and `ret_req` are high together, the call takes effect and the return is ignored.
- R9: Reads are combinational from the current `cwp`. A write lands at the clock edge and is mapped with the `cwp` in effect before any move at that edge. A read of the number being written in the same cycle returns `wr_data`.
- R10: After reset, `cwp` is 0, `ovf` and `unf` are 0, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| rd_a_num | input | 5 | Register number for read port A |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_num | input | 5 | Register number for read port B |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_num | input | 5 | Register number to write |
| wr_data | input | XLEN | Write data |
| call_req | input | 1 | Move the window pointer for a call |
| ret_req | input | 1 | Move the window pointer for a return |
| inval_mask | input | NWIN | One bit per window: 1 means the window may not be entered |
| cwp | output | $clog2(NWIN) | Current window pointer |
| ovf | output | 1 | Call blocked by an invalid window (one-cycle pulse) |
| unf | output | 1 | Return blocked by an invalid window (one-cycle pulse) |

## Verification
The bench builds the file with NWIN = 4 and XLEN = 32. Four windows let a few consecutive calls or returns wrap the pointer in both directions. The overlap between the last window and window 0 is then reached often, so the random phase repeatedly revisits windows and checks that private registers survive and that shared groups line up across the wrap. An odd or larger window count uses the same modulo arithmetic; the default of 8 is elaborated with the RTL alone.

// File: rtl/winreg_file.sv
`timescale 1ns/1ps
module winreg_file #(
  parameter int NWIN = 8,
  parameter int XLEN = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [4:0]              rd_a_num,
  output logic [XLEN-1:0]         rd_a_data,
  input  logic [4:0]              rd_b_num,
  output logic [XLEN-1:0]         rd_b_data,
  input  logic                    wr_en,
  input  logic [4:0]              wr_num,
  input  logic [XLEN-1:0]         wr_data,
  input  logic                    call_req,
  input  logic                    ret_req,
  input  logic [NWIN-1:0]         inval_mask,
  output logic [$clog2(NWIN)-1:0] cwp,
  output logic                    ovf,
  output logic                    unf
);
  localparam int WPW   = $clog2(NWIN);
  localparam int NPHYS = 8 + 16 * NWIN;
  localparam int PW    = $clog2(NPHYS);

  logic [XLEN-1:0] regs [NPHYS];
  logic [WPW-1:0]  win_dn, win_up;

  function automatic logic [PW-1:0] slot(input logic [4:0] n, input logic [WPW-1:0] w);
    int wi, wm1, k;
    wi  = int'(w);
    wm1 = (wi == 0) ? NWIN - 1 : wi - 1;
    k   = int'(n[2:0]);
    case (n[4:3])
      2'd0:    slot = PW'(k);
      2'd1:    slot = PW'(16 + 16 * wm1 + k);
      2'd2:    slot = PW'(8 + 16 * wi + k);
      default: slot = PW'(16 + 16 * wi + k);
    endcase
  endfunction

  assign win_dn = (cwp == '0) ? WPW'(NWIN - 1) : cwp - 1'b1;
  assign win_up = (cwp == WPW'(NWIN - 1)) ? '0 : cwp + 1'b1;

  assign rd_a_data = (rd_a_num == '0) ? '0 :
                     (wr_en && wr_num == rd_a_num) ? wr_data : regs[slot(rd_a_num, cwp)];
  assign rd_b_data = (rd_b_num == '0) ? '0 :
                     (wr_en && wr_num == rd_b_num) ? wr_data : regs[slot(rd_b_num, cwp)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
    end else if (wr_en && wr_num != '0) begin
      regs[slot(wr_num, cwp)] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      if (call_req) begin
        if (inval_mask[win_dn]) ovf <= 1'b1;
        else                    cwp <= win_dn;
      end else if (ret_req) begin
        if (inval_mask[win_up]) unf <= 1'b1;
        else                    cwp <= win_up;
      end
    end
  end

  assert_zero_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_num == 5'd0) |-> (rd_a_data == '0));

  assert_call_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> (ovf || ((int'(cwp) + 1) % NWIN == int'($past(cwp)))));

  assert_ret_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !call_req) |=> (unf || ((int'($past(cwp)) + 1) % NWIN == int'(cwp))));

  assert_no_overflow_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $stable(cwp));

  assert_no_underflow_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> $stable(cwp));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));

  assert_write_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_num != 5'd0 && !call_req && !ret_req) |=>
      (rd_a_num != $past(wr_num) || (wr_en && wr_num == rd_a_num) ||
       rd_a_data == $past(wr_data)));
endmodule

// File: tb/winreg_file_tb.sv
`timescale 1ns/1ps
module winreg_file_tb;
  localparam int N = 4;
  localparam int W = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic [4:0] ra = 0, rb = 0, wn = 0;
  logic [31:0] wd = 0;
  logic we = 0, call = 0, ret = 0;
  logic [N-1:0] mask = '0;
  logic [31:0] da, db;
  logic [W-1:0] cwp;
  logic ovf, unf;

  int errors = 0, checks = 0;

  logic [31:0] glob [8];
  logic [31:0] loc  [N][8];
  logic [31:0] ins  [N][8];
  int mcwp = 0;
  bit movf = 0, munf = 0;

  always #5 clk = ~clk;

  winreg_file #(.NWIN(N), .XLEN(32)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_num(ra), .rd_a_data(da), .rd_b_num(rb), .rd_b_data(db),
    .wr_en(we), .wr_num(wn), .wr_data(wd),
    .call_req(call), .ret_req(ret), .inval_mask(mask),
    .cwp(cwp), .ovf(ovf), .unf(unf));

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(int n);
    if (n == 0) return "R2";
    if (n < 8) return "R1";
    if (n < 16 || n >= 24) return "R4";
    return "R3";
  endfunction

  function automatic logic [31:0] mread(int n);
    if (n == 0) return 0;
    if (n < 8) return glob[n];
    if (n < 16) return ins[(mcwp + N - 1) % N][n - 8];
    if (n < 24) return loc[mcwp][n - 16];
    return ins[mcwp][n - 24];
  endfunction

  task automatic mwrite(int n, logic [31:0] v);
    if (n == 0) return;
    if (n < 8) glob[n] = v;
    else if (n < 16) ins[(mcwp + N - 1) % N][n - 8] = v;
    else if (n < 24) loc[mcwp][n - 16] = v;
    else ins[mcwp][n - 24] = v;
  endtask

  task automatic mclear();
    for (int i = 0; i < 8; i++) glob[i] = 0;
    for (int w = 0; w < N; w++)
      for (int i = 0; i < 8; i++) begin loc[w][i] = 0; ins[w][i] = 0; end
    mcwp = 0; movf = 0; munf = 0;
  endtask

  task automatic cyc(bit c, bit r, bit e, int n, logic [31:0] v, int a, int b, string rtag = "");
    logic [31:0] ea, eb;
    int tgt;
    @(negedge clk);
    call = c; ret = r; we = e; wn = 5'(n); wd = v; ra = 5'(a); rb = 5'(b);
    #1;
    ea = (e && n == a && a != 0) ? v : mread(a);
    eb = (e && n == b && b != 0) ? v : mread(b);
    check(da === ea, (rtag != "") ? rtag : ((e && n == a && a != 0) ? "R9" : tag_of(a)), da, ea);
    check(db === eb, (rtag != "") ? rtag : ((e && n == b && b != 0) ? "R9" : tag_of(b)), db, eb);
    @(posedge clk);
    if (e) mwrite(n, v);
    movf = 0; munf = 0;
    if (c) begin
      tgt = (mcwp + N - 1) % N;
      if (mask[tgt]) movf = 1; else mcwp = tgt;
    end else if (r) begin
      tgt = (mcwp + 1) % N;
      if (mask[tgt]) munf = 1; else mcwp = tgt;
    end
    #1;
    check(int'(cwp) == mcwp, c && r ? "R8" : "R5", 32'(cwp), 32'(mcwp));
    check(ovf === movf, "R6", 32'(ovf), 32'(movf));
    check(unf === munf, "R7", 32'(unf), 32'(munf));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mclear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10: reset state visible on every register number
    check(cwp == 0, "R10", 32'(cwp), 0);
    check(!ovf && !unf, "R10", {30'd0, ovf, unf}, 0);
    for (int n = 0; n < 32; n += 2) cyc(0, 0, 0, 0, 0, n, n + 1, "R10");

    // R2: writing g0 has no effect
    cyc(0, 0, 1, 0, 32'hDEAD_BEEF, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, 0, "R2");

    // fill window 0 with distinct values
    for (int n = 1; n < 32; n++) cyc(0, 0, 1, n, 32'h1000_0000 + 32'(n), n, 0);
    // R4: caller outgoing 8+k becomes callee incoming 24+k; R1 globals follow
    cyc(1, 0, 0, 0, 0, 0, 0);
    for (int n = 8; n < 16; n++) cyc(0, 0, 0, 0, 0, n + 16, n - 7 < 8 ? n - 7 : 1);
    // R3: write callee locals, return, caller locals intact
    for (int n = 16; n < 24; n++) cyc(0, 0, 1, n, 32'h2000_0000 + 32'(n), n, 0);
    cyc(0, 1, 0, 0, 0, 0, 0);
    for (int n = 16; n < 24; n++) cyc(0, 0, 0, 0, 0, n, n + 8, "R3");

    // R5: wrap in both directions
    for (int i = 0; i < N + 1; i++) cyc(1, 0, 0, 0, 0, 24, 8);
    for (int i = 0; i < N + 2; i++) cyc(0, 1, 0, 0, 0, 16, 9);

    // R6: blocked call
    mask = '0; mask[(mcwp + N - 1) % N] = 1'b1;
    cyc(1, 0, 0, 0, 0, 16, 24);
    cyc(0, 0, 0, 0, 0, 16, 24);
    // R7: blocked return
    mask = '0; mask[(mcwp + 1) % N] = 1'b1;
    cyc(0, 1, 0, 0, 0, 16, 24);
    cyc(0, 0, 0, 0, 0, 16, 24);
    // R8: call and return together, call wins (and is blocked by its own target)
    mask = '0;
    cyc(1, 1, 0, 0, 0, 8, 24);
    mask[(mcwp + N - 1) % N] = 1'b1;
    cyc(1, 1, 0, 0, 0, 8, 24);
    mask = '0;
    // R9: write with call in the same cycle lands in the old window
    cyc(1, 0, 1, 17, 32'hCAFE_0017, 17, 0, "R9");
    cyc(0, 1, 0, 0, 0, 17, 0, "R9");
    cyc(0, 0, 0, 0, 0, 17, 0, "R9");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 16);
      mask = ($urandom % 4 == 0) ? N'($urandom) : '0;
      cyc(r == 0, r == 1 || r == 2, ($urandom % 3) != 0, int'($urandom % 32), $urandom,
          int'($urandom % 32), int'($urandom % 32));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule